// File: doc/BRIEF.md
# Runahead Mode Sequencer with Architectural Checkpoint

This block decides when an out-of-order core leaves normal execution for a speculative runahead mode and when it comes back. It also owns the checkpointed copy of the architectural register file. In normal mode every committed, non-speculative retirement writes its result into the checkpoint, so the checkpoint is always current. Entering runahead therefore costs no copy cycles. When a load that missed the second-level cache reaches the head of the instruction window, the block records that load's instruction address together with the current branch history and return-stack values. It then raises its mode flag, and from that point the checkpoint is frozen.

When the blocking load's data comes back, the block handles the exit like a branch misprediction. It raises a one-cycle flush request and a one-cycle invalidate pulse for the runahead store cache. In the same cycle it presents the recorded refetch address and the captured history values. It then streams the checkpoint out one register per cycle. Each register goes to a fixed region of physical registers, which matches the single hard-coded mapping that both rename tables are reloaded with. A done pulse follows the last beat, and the block is back in normal mode.

Top module: `runahead_seq`

## Requirements
- R1: A synchronous active-high reset puts the block in normal mode (mode flag low, no flush, no invalidate, no restore, no done) and clears every checkpoint register to zero.
- R2: In normal mode, a head-of-window second-level-miss indication makes the mode flag high from the next cycle.
- R3: The instruction address, branch history and return-stack values present with the accepted trigger are held on the refetch and history outputs until the next accepted trigger.
- R4: In normal mode, a retirement with the valid bit set and the runahead flag clear writes its result into the checkpoint register it names; a retirement with the runahead flag set writes nothing.
- R5: While the mode flag is high, no retirement alters the checkpoint, whatever its runahead flag.
- R6: A blocking-load completion seen while in runahead produces, in the next cycle, a single-cycle flush request and a single-cycle store-cache invalidate pulse together.
- R7: In the cycle of the flush and in each of the following NREG-1 cycles, the restore stream is valid and carries checkpoint index 0, 1, ... NREG-1 in ascending order, with that register's value and physical register number PBASE+index.
- R8: The done pulse lasts one cycle and comes in the cycle right after the last restore beat; the mode flag falls in that same cycle.
- R9: A blocking-load completion in normal mode is ignored, and an entry trigger during runahead or restore is ignored (no flush, and no change to the recorded address).
- R10: A normal-mode retirement in the same cycle as an accepted entry trigger is still written to the checkpoint.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ret_vld | input | 1 | Retirement valid |
| ret_idx | input | IW | Architectural destination index |
| ret_data | input | DW | Retired result |
| ret_spec | input | 1 | Retiring instruction is a runahead operation |
| miss_head | input | 1 | Load at window head missed the second-level cache |
| miss_pc | input | AW | Instruction address of that load |
| blk_done | input | 1 | Blocking load data has returned |
| bhist_in | input | HW | Current branch history register |
| rstk_in | input | SW | Current return-stack state |
| ra_mode | output | 1 | Runahead mode (high through restore) |
| flush | output | 1 | Flush-all request, one cycle |
| inval | output | 1 | Invalidate all runahead store cache lines, one cycle |
| rest_vld | output | 1 | Restore beat valid |
| rest_idx | output | IW | Architectural index of the beat |
| rest_preg | output | PW | Physical register receiving the beat |
| rest_data | output | DW | Checkpointed value |
| rest_done | output | 1 | Restore finished, one cycle |
| resume_pc | output | AW | Refetch address |
| bhist_out | output | HW | Captured branch history |
| rstk_out | output | SW | Captured return-stack state |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a normal-mode retirement and the entry trigger that closes normal mode. The bench drives both on one edge, and the later restore stream must carry the retired value. The second pair is the last restore beat followed directly by a new trigger in the done cycle. The bench issues that trigger on the first cycle back in normal mode, and the reference model judges it, comparing mode, pulses, stream and captured address on every clock.

// File: rtl/ra_pkg.sv
package ra_pkg;

    typedef enum logic [1:0] {
        RA_NORMAL  = 2'd0,
        RA_SPEC    = 2'd1,
        RA_RESTORE = 2'd2
    } ra_state_e;

    function automatic logic ra_is_last(input int unsigned cnt, input int unsigned nreg);
        return cnt == nreg - 1;
    endfunction

endpackage

// File: rtl/ra_ckpt_file.sv
module ra_ckpt_file #(
    parameter int NREG = 8,
    parameter int DW   = 32,
    localparam int IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (wr_en) begin
            regs[wr_idx] <= wr_data;
        end
    end

    assign rd_data = regs[rd_idx];
endmodule

// File: rtl/ra_snapshot.sv
module ra_snapshot #(
    parameter int AW = 32,
    parameter int HW = 16,
    parameter int SW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cap,
    input  logic [AW-1:0] pc_in,
    input  logic [HW-1:0] bh_in,
    input  logic [SW-1:0] rs_in,
    output logic [AW-1:0] pc_q,
    output logic [HW-1:0] bh_q,
    output logic [SW-1:0] rs_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
            bh_q <= '0;
            rs_q <= '0;
        end else if (cap) begin
            pc_q <= pc_in;
            bh_q <= bh_in;
            rs_q <= rs_in;
        end
    end
endmodule

// File: rtl/ra_mode_fsm.sv
module ra_mode_fsm
    import ra_pkg::*;
#(
    parameter int NREG = 8,
    localparam int IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          trig,
    input  logic          blk_done,
    output ra_state_e     state,
    output logic [IW-1:0] cnt,
    output logic          cap,
    output logic          flush,
    output logic          inval,
    output logic          done
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RA_NORMAL;
            cnt   <= '0;
            flush <= 1'b0;
            inval <= 1'b0;
            done  <= 1'b0;
        end else begin
            flush <= 1'b0;
            inval <= 1'b0;
            done  <= 1'b0;
            unique case (state)
                RA_NORMAL: begin
                    if (trig) state <= RA_SPEC;
                end
                RA_SPEC: begin
                    if (blk_done) begin
                        state <= RA_RESTORE;
                        cnt   <= '0;
                        flush <= 1'b1;
                        inval <= 1'b1;
                    end
                end
                RA_RESTORE: begin
                    if (ra_is_last(32'(cnt), NREG)) begin
                        state <= RA_NORMAL;
                        done  <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= RA_NORMAL;
            endcase
        end
    end

    // entry is only accepted in normal mode; triggers elsewhere are dropped
    assign cap = (state == RA_NORMAL) && trig;
endmodule

// File: rtl/runahead_seq.sv
module runahead_seq
    import ra_pkg::*;
#(
    parameter int NREG  = 8,
    parameter int DW    = 32,
    parameter int AW    = 32,
    parameter int HW    = 16,
    parameter int SW    = 32,
    parameter int PW    = 7,
    parameter int PBASE = 0,
    localparam int IW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ret_vld,
    input  logic [IW-1:0] ret_idx,
    input  logic [DW-1:0] ret_data,
    input  logic          ret_spec,
    input  logic          miss_head,
    input  logic [AW-1:0] miss_pc,
    input  logic          blk_done,
    input  logic [HW-1:0] bhist_in,
    input  logic [SW-1:0] rstk_in,
    output logic          ra_mode,
    output logic          flush,
    output logic          inval,
    output logic          rest_vld,
    output logic [IW-1:0] rest_idx,
    output logic [PW-1:0] rest_preg,
    output logic [DW-1:0] rest_data,
    output logic          rest_done,
    output logic [AW-1:0] resume_pc,
    output logic [HW-1:0] bhist_out,
    output logic [SW-1:0] rstk_out
);
    ra_state_e     state;
    logic [IW-1:0] cnt;
    logic          cap;
    logic          ck_we;

    ra_mode_fsm #(.NREG(NREG)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .trig     (miss_head),
        .blk_done (blk_done),
        .state    (state),
        .cnt      (cnt),
        .cap      (cap),
        .flush    (flush),
        .inval    (inval),
        .done     (rest_done)
    );

    // checkpoint follows committed retirement only while in normal mode
    assign ck_we = ret_vld && !ret_spec && (state == RA_NORMAL);

    ra_ckpt_file #(.NREG(NREG), .DW(DW)) u_ckpt (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (ck_we),
        .wr_idx  (ret_idx),
        .wr_data (ret_data),
        .rd_idx  (cnt),
        .rd_data (rest_data)
    );

    ra_snapshot #(.AW(AW), .HW(HW), .SW(SW)) u_snap (
        .clk   (clk),
        .rst   (rst),
        .cap   (cap),
        .pc_in (miss_pc),
        .bh_in (bhist_in),
        .rs_in (rstk_in),
        .pc_q  (resume_pc),
        .bh_q  (bhist_out),
        .rs_q  (rstk_out)
    );

    assign ra_mode   = (state != RA_NORMAL);
    assign rest_vld  = (state == RA_RESTORE);
    assign rest_idx  = cnt;
    assign rest_preg = PW'(PBASE) + PW'(cnt);
endmodule

// File: rtl/ra_seq_chk.sv
module ra_seq_chk #(
    parameter int NREG = 8,
    parameter int AW   = 32,
    localparam int IW  = $clog2(NREG)
) (
    input logic          clk,
    input logic          rst,
    input logic          miss_head,
    input logic          blk_done,
    input logic          ra_mode,
    input logic          flush,
    input logic          inval,
    input logic          rest_vld,
    input logic [IW-1:0] rest_idx,
    input logic          rest_done,
    input logic [AW-1:0] resume_pc
);
    p_entry_r2: assert property (@(posedge clk) disable iff (rst)
        (!ra_mode && miss_head) |=> ra_mode);

    p_hold_pc_r3: assert property (@(posedge clk) disable iff (rst)
        (ra_mode && $past(ra_mode)) |-> $stable(resume_pc));

    p_flush_in_mode_r6: assert property (@(posedge clk) disable iff (rst)
        flush |-> (ra_mode && inval && rest_vld && rest_idx == '0));

    p_flush_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        flush |=> !flush);

    p_stream_step_r7: assert property (@(posedge clk) disable iff (rst)
        (rest_vld && $past(rest_vld)) |-> (rest_idx == $past(rest_idx) + 1'b1));

    p_done_after_last_r8: assert property (@(posedge clk) disable iff (rst)
        rest_done |-> (!ra_mode && $past(rest_vld) && $past(rest_idx) == IW'(NREG - 1)));

    p_ignore_done_r9: assert property (@(posedge clk) disable iff (rst)
        (!ra_mode && blk_done) |=> !flush);
endmodule

bind runahead_seq ra_seq_chk #(.NREG(NREG), .AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .miss_head (miss_head),
    .blk_done  (blk_done),
    .ra_mode   (ra_mode),
    .flush     (flush),
    .inval     (inval),
    .rest_vld  (rest_vld),
    .rest_idx  (rest_idx),
    .rest_done (rest_done),
    .resume_pc (resume_pc)
);

// File: tb/test_runahead_seq.sv
`timescale 1ns/1ps
module test_runahead_seq;
    localparam int NREG  = 8;
    localparam int DW    = 32;
    localparam int AW    = 32;
    localparam int HW    = 16;
    localparam int SW    = 32;
    localparam int PW    = 7;
    localparam int PBASE = 32;
    localparam int IW    = $clog2(NREG);

    logic clk = 0, rst = 1;
    logic ret_vld = 0, ret_spec = 0, miss_head = 0, blk_done = 0;
    logic [IW-1:0] ret_idx = '0;
    logic [DW-1:0] ret_data = '0;
    logic [AW-1:0] miss_pc = '0;
    logic [HW-1:0] bhist_in = '0;
    logic [SW-1:0] rstk_in = '0;
    logic ra_mode, flush, inval, rest_vld, rest_done;
    logic [IW-1:0] rest_idx;
    logic [PW-1:0] rest_preg;
    logic [DW-1:0] rest_data;
    logic [AW-1:0] resume_pc;
    logic [HW-1:0] bhist_out;
    logic [SW-1:0] rstk_out;

    always #2.5 clk = ~clk;

    runahead_seq #(.NREG(NREG), .DW(DW), .AW(AW), .HW(HW), .SW(SW), .PW(PW), .PBASE(PBASE)) i_runahead_seq (
        .clk(clk), .rst(rst), .ret_vld(ret_vld), .ret_idx(ret_idx), .ret_data(ret_data),
        .ret_spec(ret_spec), .miss_head(miss_head), .miss_pc(miss_pc), .blk_done(blk_done),
        .bhist_in(bhist_in), .rstk_in(rstk_in), .ra_mode(ra_mode), .flush(flush), .inval(inval),
        .rest_vld(rest_vld), .rest_idx(rest_idx), .rest_preg(rest_preg), .rest_data(rest_data),
        .rest_done(rest_done), .resume_pc(resume_pc), .bhist_out(bhist_out), .rstk_out(rstk_out)
    );

    int checks = 0, failures = 0;
    string tag = "R1";
    bit started = 0;
    bit finished = 0;

    // behavioural reference: mode 0 normal, 1 speculative, 2 restoring
    int          m_mode = 0, m_cnt = 0;
    bit          m_flush = 0, m_inval = 0, m_done = 0;
    int unsigned m_ck [NREG];
    int unsigned m_pc = 0, m_bh = 0, m_rs = 0;

    always @(posedge clk) begin
        started <= 1;
        if (rst) begin
            m_mode <= 0; m_cnt <= 0; m_flush <= 0; m_inval <= 0; m_done <= 0;
            m_pc <= 0; m_bh <= 0; m_rs <= 0;
            for (int i = 0; i < NREG; i++) m_ck[i] <= 0;
        end else begin
            m_flush <= 0; m_inval <= 0; m_done <= 0;
            if (m_mode == 0) begin
                if (ret_vld && !ret_spec) m_ck[ret_idx] <= ret_data;
                if (miss_head) begin
                    m_mode <= 1; m_pc <= miss_pc; m_bh <= bhist_in; m_rs <= rstk_in;
                end
            end else if (m_mode == 1) begin
                if (blk_done) begin
                    m_mode <= 2; m_cnt <= 0; m_flush <= 1; m_inval <= 1;
                end
            end else begin
                if (m_cnt == NREG - 1) begin
                    m_mode <= 0; m_done <= 1;
                end else m_cnt <= m_cnt + 1;
            end
        end
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s [%s] %s actual=%0h expected=%0h t=%0t", req, tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started && !finished) begin
            chk("R2", "ra_mode", ra_mode, m_mode != 0);
            chk("R6", "flush", flush, m_flush);
            chk("R6", "inval", inval, m_inval);
            chk("R8", "rest_done", rest_done, m_done);
            chk("R7", "rest_vld", rest_vld, m_mode == 2);
            chk("R3", "resume_pc", resume_pc, m_pc);
            chk("R3", "bhist_out", bhist_out, m_bh);
            chk("R3", "rstk_out", rstk_out, m_rs);
            if (m_mode == 2) begin
                chk("R7", "rest_idx", rest_idx, m_cnt);
                chk("R7", "rest_preg", rest_preg, PBASE + m_cnt);
                chk("R7", "rest_data", rest_data, m_ck[m_cnt]);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) begin
            @(negedge clk); #1;
            ret_vld = 0; ret_spec = 0; miss_head = 0; blk_done = 0;
        end
    endtask

    task automatic retire(input int idx, input int unsigned d, input bit spec);
        @(negedge clk); #1;
        ret_vld = 1; ret_idx = IW'(idx); ret_data = d; ret_spec = spec;
        miss_head = 0; blk_done = 0;
    endtask

    task automatic trigger(input int unsigned pc, input bit with_retire, input int idx, input int unsigned d);
        @(negedge clk); #1;
        miss_head = 1; miss_pc = pc; bhist_in = HW'(pc ^ 16'h5a5a); rstk_in = pc + 32'h100;
        blk_done = 0; ret_vld = with_retire; ret_idx = IW'(idx); ret_data = d; ret_spec = 0;
    endtask

    task automatic complete();
        @(negedge clk); #1;
        blk_done = 1; miss_head = 0; ret_vld = 0;
    endtask

    initial begin
        tag = "R1";
        step(3);
        rst = 0;
        step(2);
        // R1: cleared checkpoint is visible through a first restore
        trigger(32'h1000, 0, 0, 0);
        step(2);
        complete();
        step(NREG + 3);

        tag = "R4";
        for (int i = 0; i < NREG; i++) retire(i, 32'hA000_0000 + i * 32'h111, 0);
        retire(3, 32'hDEAD_0003, 1);       // runahead-flagged: no write
        tag = "R9";
        complete();                        // completion in normal mode: ignored
        step(3);
        tag = "R10";
        trigger(32'h2040, 1, 5, 32'hC0DE_0005);
        tag = "R5";
        retire(1, 32'hBAD0_0001, 0);
        retire(2, 32'hBAD0_0002, 1);
        tag = "R9";
        trigger(32'h9999, 0, 0, 0);        // second trigger while speculative
        step(2);
        tag = "R6";
        complete();
        tag = "R9";
        trigger(32'h7777, 1, 6, 32'hBAD0_0006); // during restore: ignored
        tag = "R7";
        step(NREG - 1);
        tag = "R8";
        trigger(32'h3300, 1, 0, 32'h1234_5678); // accepted right in the done cycle
        step(1);
        retire(4, 32'hBAD0_0004, 0);
        complete();
        step(NREG + 3);

        tag = "R1";
        rst = 1;
        step(2);
        rst = 0;
        step(2);
        trigger(32'h4400, 0, 0, 0);
        step(1);
        complete();
        step(NREG + 3);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule